// File: doc/BRIEF.md
# Remote DMA Data-Port Engine

This block lets a host move data to or from a local byte-wide buffer RAM through a single data port. The host first programs a 16-bit buffer address and a 16-bit transfer count, each as a low byte and a high byte, through a small register port. It then issues data-port accesses, each one a strobe. Each access moves one byte, or two bytes when the word-mode configuration bit is set. After each access the engine advances the address, folding it back from the ring end to the ring start. It also lowers the count and raises a completion flag in a status register once the count runs out.

The RAM is synchronous and one byte wide, so a word access takes two internal RAM cycles. Completion of every access is marked by a one-cycle acknowledge pulse, with read data valid during that pulse. Only two address windows are backed by storage: a small low area and a larger buffer window. Reads outside both return all ones, and writes outside both are dropped. A command write that requests a remote read or write while the count is zero raises the completion flag at once.

Register map on `reg_addr_i`:
- 0: command, write-only. Bit 0 requests a remote read and bit 1 requests a remote write.
- 1 and 2: address, low byte and high byte.
- 3 and 4: count, low byte and high byte.
- 5: ring start page, the high byte of the wrap target.
- 6: ring end page, the high byte of the wrap trigger.
- 7: configuration. Bit 0 selects word mode.
- 8: status. Bit 6 is the completion flag, cleared by writing a 1 to it.

Unlisted offsets, and reads of offset 0, return 0.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the address, count, ring pages, configuration and status all read 0, and `dp_ack_o` is low.
- R2: A write to a low register (offset 1 or 3) replaces bits 7:0 of the address or count and keeps bits 15:8. A write to a high register (offset 2 or 4) replaces bits 15:8 and keeps bits 7:0.
- R3: In byte mode (configuration bit 0 = 0) an access transfers one byte at the current address. `dp_ack_o` pulses 2 cycles after the cycle in which `dp_req_i` was sampled, and the byte read appears on `dp_rdata_o[7:0]` with bits 15:8 at 0.
- R4: In word mode an access transfers two bytes at the address with bit 0 forced to 0, little-endian: the lower address goes on bits 7:0. `dp_ack_o` pulses 3 cycles after the request.
- R5: After an access the address grows by the transfer size (1 or 2). If the result equals the ring end page times 256, the address becomes the ring start page times 256.
- R6: If the count is at most the transfer size, the count becomes 0 and status bit 6 is set. Otherwise the count drops by the transfer size.
- R7: A data-port write while the count is 0 changes no RAM byte, address or count, and is still acknowledged.
- R8: A data-port read while the count is 0 still returns data, advances the address and sets status bit 6.
- R9: Addresses below LOW_BYTES (32) and from WIN_BASE (16384) up to WIN_BASE+WIN_BYTES-1 are backed by RAM. Reads elsewhere return 0xFF per byte, and writes elsewhere are discarded.
- R10: A command write with bit 0 or bit 1 set while the count is 0 sets status bit 6 by the next cycle. With a nonzero count it does not.
- R11: Writing status with bit 6 = 1 clears the completion flag. Writing bit 6 = 0 leaves it as it was.
- R12: `dp_ack_o` is high for exactly one cycle per access, and a request that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on offset) |
| dp_req_i | input | 1 | Data-port access request, one cycle |
| dp_we_i | input | 1 | 1 = data-port write, 0 = read |
| dp_wdata_i | input | 16 | Data-port write data |
| dp_ack_o | output | 1 | Access complete pulse |
| dp_rdata_o | output | 16 | Read data, valid with dp_ack_o |
| stat_o | output | 8 | Status register, bit 6 = transfer complete |

## Verification
A byte access acknowledges 2 cycles after its request is sampled and a word access 3 cycles after. The address, count and status update at the clock edge that closes the acknowledge cycle, so they can be read one cycle after the acknowledge. A command write affects status at the very next edge. The scoreboard records the cycle of each request, along with the expected data and latency. The monitor counts cycles on the falling edge and checks both when the acknowledge arrives. Register checks are made only after the driver has waited out the update cycle.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_DONE
  } seq_st_e;

  localparam logic [3:0] REG_CMD      = 4'd0;
  localparam logic [3:0] REG_ADR_LO   = 4'd1;
  localparam logic [3:0] REG_ADR_HI   = 4'd2;
  localparam logic [3:0] REG_CNT_LO   = 4'd3;
  localparam logic [3:0] REG_CNT_HI   = 4'd4;
  localparam logic [3:0] REG_RING_BEG = 4'd5;
  localparam logic [3:0] REG_RING_END = 4'd6;
  localparam logic [3:0] REG_CFG      = 4'd7;
  localparam logic [3:0] REG_STAT     = 4'd8;

  localparam int CMD_RD_BIT    = 0;
  localparam int CMD_WR_BIT    = 1;
  localparam int CFG_WORD_BIT  = 0;
  localparam int STAT_DONE_BIT = 6;

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    sel_i,
  input  logic [7:0]    wr_data_i,
  output logic [7:0]    rd_data_o,
  input  logic          upd_i,
  input  logic [1:0]    step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_zero_o,
  output logic          word_mode_o,
  output logic          done_o,
  output logic [AW-9:0] ring_beg_o,
  output logic [AW-9:0] ring_end_o
);

  localparam int PW = AW - 8;

  logic [AW-1:0] addr_q, addr_inc;
  logic [CW-1:0] cnt_q, step_c;
  logic [PW-1:0] ring_beg_q, ring_end_q;
  logic [7:0]    cfg_q;
  logic          done_q, done_set, done_clr, wrap, exhaust;

  assign addr_inc = addr_q + {{(AW-2){1'b0}}, step_i};
  assign step_c   = {{(CW-2){1'b0}}, step_i};
  assign wrap     = (addr_inc == {ring_end_q, 8'h00});
  assign exhaust  = (cnt_q <= step_c);

  assign done_set = (upd_i && exhaust) ||
                    (wr_en_i && sel_i == REG_CMD &&
                     (wr_data_i[CMD_RD_BIT] || wr_data_i[CMD_WR_BIT]) &&
                     cnt_q == '0);
  assign done_clr = wr_en_i && sel_i == REG_STAT && wr_data_i[STAT_DONE_BIT];

  // DMA progress takes precedence over host reloads in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (upd_i) begin
      addr_q <= wrap ? {ring_beg_q, 8'h00} : addr_inc;
      cnt_q  <= exhaust ? '0 : cnt_q - step_c;
    end else if (wr_en_i) begin
      case (sel_i)
        REG_ADR_LO: addr_q[7:0]    <= wr_data_i;
        REG_ADR_HI: addr_q[AW-1:8] <= wr_data_i[PW-1:0];
        REG_CNT_LO: cnt_q[7:0]     <= wr_data_i;
        REG_CNT_HI: cnt_q[CW-1:8]  <= wr_data_i[CW-9:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_beg_q <= '0;
      ring_end_q <= '0;
      cfg_q      <= '0;
    end else if (wr_en_i) begin
      case (sel_i)
        REG_RING_BEG: ring_beg_q <= wr_data_i[PW-1:0];
        REG_RING_END: ring_end_q <= wr_data_i[PW-1:0];
        REG_CFG:      cfg_q      <= wr_data_i;
        default: ;
      endcase
    end
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_set | (done_q & ~done_clr);
  end

  always_comb begin
    rd_data_o = 8'h00;
    case (sel_i)
      REG_ADR_LO:   rd_data_o = addr_q[7:0];
      REG_ADR_HI:   rd_data_o = 8'(addr_q[AW-1:8]);
      REG_CNT_LO:   rd_data_o = cnt_q[7:0];
      REG_CNT_HI:   rd_data_o = 8'(cnt_q[CW-1:8]);
      REG_RING_BEG: rd_data_o = 8'(ring_beg_q);
      REG_RING_END: rd_data_o = 8'(ring_end_q);
      REG_CFG:      rd_data_o = cfg_q;
      REG_STAT:     rd_data_o = 8'(done_q) << STAT_DONE_BIT;
      default:      rd_data_o = 8'h00;
    endcase
  end

  assign addr_o      = addr_q;
  assign cnt_o       = cnt_q;
  assign cnt_zero_o  = (cnt_q == '0);
  assign word_mode_o = cfg_q[CFG_WORD_BIT];
  assign done_o      = done_q;
  assign ring_beg_o  = ring_beg_q;
  assign ring_end_o  = ring_end_q;

endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
  import rdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [15:0]   wdata_i,
  input  logic          word_mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic          cnt_zero_i,
  input  logic [7:0]    ram_q_i,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_d_o,
  output logic          ack_o,
  output logic [15:0]   rdata_o,
  output logic          upd_o,
  output logic [1:0]    step_o
);

  seq_st_e       st_q;
  logic          we_q, word_q, void_q;
  logic [15:0]   wd_q;
  logic [AW-1:0] base_q;
  logic [7:0]    lo_q;
  logic          in_ram_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      we_q   <= 1'b0;
      word_q <= 1'b0;
      void_q <= 1'b0;
      wd_q   <= '0;
      base_q <= '0;
      lo_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          we_q   <= we_i;
          word_q <= word_mode_i;
          void_q <= we_i & cnt_zero_i;
          wd_q   <= wdata_i;
          base_q <= word_mode_i ? {addr_i[AW-1:1], 1'b0} : addr_i;
          st_q   <= ST_LO;
        end
        ST_LO:   st_q <= word_q ? ST_HI : ST_DONE;
        ST_HI: begin
          lo_q <= ram_q_i;
          st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ram_phase = (st_q == ST_LO) || (st_q == ST_HI);
  assign ram_en_o     = in_ram_phase && !(we_q && void_q);
  assign ram_we_o     = ram_en_o && we_q;
  assign ram_addr_o   = (st_q == ST_HI) ? (base_q | {{(AW-1){1'b0}}, 1'b1}) : base_q;
  assign ram_d_o      = (st_q == ST_HI) ? wd_q[15:8] : wd_q[7:0];

  assign ack_o  = (st_q == ST_DONE);
  assign upd_o  = (st_q == ST_DONE) && !(we_q && void_q);
  assign step_o = word_q ? 2'd2 : 2'd1;

  always_comb begin
    rdata_o = 16'h0000;
    if (st_q == ST_DONE && !we_q)
      rdata_o = word_q ? {ram_q_i, lo_q} : {8'h00, ram_q_i};
  end

endmodule

// File: rtl/rdma_byte_ram.sv
module rdma_byte_ram #(
  parameter int AW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 16384,
  parameter int WIN_BYTES = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    d_i,
  output logic [7:0]    q_o
);

  localparam int DEPTH = LOW_BYTES + WIN_BYTES;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   WIN_LO  = (AW+1)'(WIN_BASE);
  localparam logic [AW:0]   WIN_HI  = (AW+1)'(WIN_BASE + WIN_BYTES);
  localparam logic [AW-1:0] WIN_OFS = AW'(WIN_BASE - LOW_BYTES);

  logic [7:0]    mem [DEPTH];
  logic [7:0]    q_q;
  logic          low_hit, win_hit, hit;
  logic [IW-1:0] idx;
  logic [AW:0]   a_ext;

  assign a_ext   = {1'b0, addr_i};
  assign win_hit = (a_ext >= WIN_LO) && (a_ext < WIN_HI);

  generate
    if (LOW_BYTES > 0) begin : g_low
      localparam logic [AW:0] LOW_HI = (AW+1)'(LOW_BYTES);
      assign low_hit = (a_ext < LOW_HI);
    end else begin : g_nolow
      assign low_hit = 1'b0;
    end
  endgenerate

  assign hit = low_hit || win_hit;
  assign idx = low_hit ? IW'(addr_i) : IW'(addr_i - WIN_OFS);

  always_ff @(posedge clk_i) begin
    if (en_i && we_i && hit) mem[idx] <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_q <= 8'h00;
    else if (en_i && !we_i) q_q <= hit ? mem[idx] : 8'hFF;
  end

  assign q_o = q_q;

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 16384,
  parameter int WIN_BYTES = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        dp_req_i,
  input  logic        dp_we_i,
  input  logic [15:0] dp_wdata_i,
  output logic        dp_ack_o,
  output logic [15:0] dp_rdata_o,
  output logic [7:0]  stat_o
);

  logic [AW-1:0] cur_addr, ram_addr;
  logic [CW-1:0] cur_cnt;
  logic [AW-9:0] ring_beg, ring_end;
  logic [1:0]    step;
  logic [7:0]    ram_d, ram_q;
  logic          upd, cnt_zero, word_mode, done, ram_en, ram_we;

  rdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (reg_we_i),
    .sel_i       (reg_addr_i),
    .wr_data_i   (reg_wdata_i),
    .rd_data_o   (reg_rdata_o),
    .upd_i       (upd),
    .step_i      (step),
    .addr_o      (cur_addr),
    .cnt_o       (cur_cnt),
    .cnt_zero_o  (cnt_zero),
    .word_mode_o (word_mode),
    .done_o      (done),
    .ring_beg_o  (ring_beg),
    .ring_end_o  (ring_end)
  );

  rdma_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (dp_req_i),
    .we_i        (dp_we_i),
    .wdata_i     (dp_wdata_i),
    .word_mode_i (word_mode),
    .addr_i      (cur_addr),
    .cnt_zero_i  (cnt_zero),
    .ram_q_i     (ram_q),
    .ram_en_o    (ram_en),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_d_o     (ram_d),
    .ack_o       (dp_ack_o),
    .rdata_o     (dp_rdata_o),
    .upd_o       (upd),
    .step_o      (step)
  );

  rdma_byte_ram #(
    .AW(AW), .LOW_BYTES(LOW_BYTES), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
  ) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ram_en),
    .we_i   (ram_we),
    .addr_i (ram_addr),
    .d_i    (ram_d),
    .q_o    (ram_q)
  );

  assign stat_o = 8'(done) << STAT_DONE_BIT;

endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [3:0]    reg_addr_i,
  input logic [7:0]    reg_wdata_i,
  input logic          dp_ack_o,
  input logic [7:0]    stat_o,
  input logic          upd,
  input logic [1:0]    step,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_cnt,
  input logic [AW-9:0] ring_beg,
  input logic [AW-9:0] ring_end,
  input logic          ram_we
);

  logic [AW-1:0] nxt_addr;
  logic [CW-1:0] step_c;
  assign nxt_addr = cur_addr + {{(AW-2){1'b0}}, step};
  assign step_c   = {{(CW-2){1'b0}}, step};

  a_r12_ack_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_ack_o |=> !dp_ack_o);

  a_r6_count_exhausts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && cur_cnt <= step_c) |=> (cur_cnt == '0 && stat_o[6]));

  a_r6_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && cur_cnt > step_c) |=> (cur_cnt == $past(cur_cnt) - $past(step_c)));

  a_r5_ring_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && nxt_addr == {ring_end, 8'h00}) |=> (cur_addr == {$past(ring_beg), 8'h00}));

  a_r7_no_write_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> (cur_cnt != '0));

  a_r10_zero_cmd_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd0 && (reg_wdata_i[0] || reg_wdata_i[1]) && cur_cnt == '0)
    |=> stat_o[6]);

endmodule

bind rdma_port_engine rdma_port_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .dp_ack_o    (dp_ack_o),
  .stat_o      (stat_o),
  .upd         (upd),
  .step        (step),
  .cur_addr    (cur_addr),
  .cur_cnt     (cur_cnt),
  .ring_beg    (ring_beg),
  .ring_end    (ring_end),
  .ram_we      (ram_we)
);

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        dp_req_i = 1'b0;
  logic        dp_we_i = 1'b0;
  logic [15:0] dp_wdata_i = '0;
  logic        dp_ack_o;
  logic [15:0] dp_rdata_o;
  logic [7:0]  stat_o;

  always #4 clk_i = ~clk_i;

  rdma_port_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .dp_req_i(dp_req_i), .dp_we_i(dp_we_i), .dp_wdata_i(dp_wdata_i),
    .dp_ack_o(dp_ack_o), .dp_rdata_o(dp_rdata_o), .stat_o(stat_o)
  );

  typedef struct {
    logic [15:0] d;
    int          t;
    int          lat;
    bit          chk;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0, acks = 0;
  bit finished = 1'b0;

  // monitor / scoreboard
  always @(negedge clk_i) begin
    cyc++;
    if (dp_ack_o) begin
      acks++;
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12 unexpected ack: actual=1 expected=0");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (cyc - it.t != it.lat) begin
          n_bad++;
          $display("FAIL %s ack latency: actual=%0d expected=%0d", it.tag, cyc - it.t, it.lat);
        end
        if (it.chk) begin
          n_chk++;
          if (dp_rdata_o !== it.d) begin
            n_bad++;
            $display("FAIL %s read data: actual=%h expected=%h", it.tag, dp_rdata_o, it.d);
          end
        end
      end
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    reg_addr_i = a; #1;
    n_chk++;
    if (reg_rdata_o !== e) begin
      n_bad++;
      $display("FAIL %s reg %0d: actual=%h expected=%h", tag, a, reg_rdata_o, e);
    end
  endtask

  task automatic set_addr(input logic [15:0] v);
    wr_reg(4'd1, v[7:0]); wr_reg(4'd2, v[15:8]);
  endtask
  task automatic set_cnt(input logic [15:0] v);
    wr_reg(4'd3, v[7:0]); wr_reg(4'd4, v[15:8]);
  endtask
  task automatic chk_addr(input logic [15:0] e, input string tag);
    chk_reg(4'd1, e[7:0], tag); chk_reg(4'd2, e[15:8], tag);
  endtask
  task automatic chk_cnt(input logic [15:0] e, input string tag);
    chk_reg(4'd3, e[7:0], tag); chk_reg(4'd4, e[15:8], tag);
  endtask

  // driver: push expectation, pulse request, wait for ack and the update cycle
  task automatic dp(input bit we, input logic [15:0] wd, input logic [15:0] e,
                    input bit chk, input int lat, input string tag);
    int a0;
    item_t it;
    @(negedge clk_i); #1;
    it.d = e; it.t = cyc; it.lat = lat; it.chk = chk; it.tag = tag;
    exp_q.push_back(it);
    a0 = acks;
    dp_req_i = 1'b1; dp_we_i = we; dp_wdata_i = wd;
    @(negedge clk_i); #1;
    dp_req_i = 1'b0;
    for (int i = 0; i < 8 && acks == a0; i++) begin
      @(negedge clk_i); #1;
    end
    if (acks == a0) begin
      n_chk++; n_bad++;
      $display("FAIL %s no ack: actual=0 expected=1", tag);
      void'(exp_q.pop_front());
    end
    @(negedge clk_i); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;

    // R1 reset state
    chk_addr(16'h0000, "R1");
    chk_cnt(16'h0000, "R1");
    chk_reg(4'd5, 8'h00, "R1");
    chk_reg(4'd6, 8'h00, "R1");
    chk_reg(4'd7, 8'h00, "R1");
    chk_reg(4'd8, 8'h00, "R1");
    n_chk++;
    if (dp_ack_o !== 1'b0) begin n_bad++; $display("FAIL R1 ack: actual=%b expected=0", dp_ack_o); end

    // R10 zero-length command, R11 clear
    wr_reg(4'd0, 8'h01);
    chk_reg(4'd8, 8'h40, "R10");
    wr_reg(4'd8, 8'hBF);
    chk_reg(4'd8, 8'h40, "R11");
    wr_reg(4'd8, 8'h40);
    chk_reg(4'd8, 8'h00, "R11");
    set_cnt(16'h0005);
    wr_reg(4'd0, 8'h02);
    chk_reg(4'd8, 8'h00, "R10");

    // R2 byte-lane loading
    set_addr(16'h4034);
    chk_addr(16'h4034, "R2");
    wr_reg(4'd1, 8'h00);
    chk_addr(16'h4000, "R2");
    wr_reg(4'd4, 8'h12);
    chk_cnt(16'h1205, "R2");

    wr_reg(4'd5, 8'h40);
    wr_reg(4'd6, 8'h48);

    // R3 byte writes, R6 count
    set_addr(16'h4000); set_cnt(16'd4);
    dp(1'b1, 16'h00A1, 16'h0, 1'b0, 2, "R3");
    chk_addr(16'h4001, "R5"); chk_cnt(16'd3, "R6");
    dp(1'b1, 16'h00A2, 16'h0, 1'b0, 2, "R3");
    dp(1'b1, 16'h00A3, 16'h0, 1'b0, 2, "R3");
    chk_reg(4'd8, 8'h00, "R6");
    dp(1'b1, 16'h00A4, 16'h0, 1'b0, 2, "R3");
    chk_cnt(16'd0, "R6"); chk_reg(4'd8, 8'h40, "R6");

    // R7 write at zero count ignored
    set_addr(16'h4000);
    dp(1'b1, 16'h0055, 16'h0, 1'b0, 2, "R7");
    chk_addr(16'h4000, "R7"); chk_cnt(16'd0, "R7");
    wr_reg(4'd8, 8'h40);

    // R3 byte reads
    set_cnt(16'd4);
    dp(1'b0, 16'h0, 16'h00A1, 1'b1, 2, "R7");
    dp(1'b0, 16'h0, 16'h00A2, 1'b1, 2, "R3");
    dp(1'b0, 16'h0, 16'h00A3, 1'b1, 2, "R3");
    dp(1'b0, 16'h0, 16'h00A4, 1'b1, 2, "R3");

    // R4 word reads, odd start address forced even
    wr_reg(4'd8, 8'h40);
    wr_reg(4'd7, 8'h01);
    set_addr(16'h4001); set_cnt(16'd4);
    dp(1'b0, 16'h0, 16'hA2A1, 1'b1, 3, "R4");
    chk_addr(16'h4003, "R4"); chk_cnt(16'd2, "R6");
    dp(1'b0, 16'h0, 16'hA4A3, 1'b1, 3, "R4");
    chk_cnt(16'd0, "R6"); chk_reg(4'd8, 8'h40, "R6");

    // R4 word writes, R6 odd count
    wr_reg(4'd8, 8'h40);
    set_addr(16'h4010); set_cnt(16'd3);
    dp(1'b1, 16'hBEEF, 16'h0, 1'b0, 3, "R4");
    chk_cnt(16'd1, "R6");
    dp(1'b1, 16'hCAFE, 16'h0, 1'b0, 3, "R4");
    chk_cnt(16'd0, "R6"); chk_addr(16'h4014, "R5"); chk_reg(4'd8, 8'h40, "R6");
    wr_reg(4'd7, 8'h00);
    set_addr(16'h4010); set_cnt(16'd4);
    dp(1'b0, 16'h0, 16'h00EF, 1'b1, 2, "R4");
    dp(1'b0, 16'h0, 16'h00BE, 1'b1, 2, "R4");
    dp(1'b0, 16'h0, 16'h00FE, 1'b1, 2, "R4");
    dp(1'b0, 16'h0, 16'h00CA, 1'b1, 2, "R4");

    // R9 memory windows
    set_addr(16'h0100); set_cnt(16'd8);
    dp(1'b0, 16'h0, 16'h00FF, 1'b1, 2, "R9");
    set_addr(16'h0020);
    dp(1'b1, 16'h005A, 16'h0, 1'b0, 2, "R9");
    set_addr(16'h0020);
    dp(1'b0, 16'h0, 16'h00FF, 1'b1, 2, "R9");
    set_addr(16'h4000);
    dp(1'b0, 16'h0, 16'h00A1, 1'b1, 2, "R9");
    set_addr(16'h001F);
    dp(1'b1, 16'h0077, 16'h0, 1'b0, 2, "R9");
    set_addr(16'h001F);
    dp(1'b0, 16'h0, 16'h0077, 1'b1, 2, "R9");
    wr_reg(4'd7, 8'h01);
    set_addr(16'h2000);
    dp(1'b0, 16'h0, 16'hFFFF, 1'b1, 3, "R9");

    // R5 ring wrap, byte and word
    wr_reg(4'd7, 8'h00);
    set_addr(16'h47FE); set_cnt(16'd10);
    dp(1'b1, 16'h0011, 16'h0, 1'b0, 2, "R5");
    chk_addr(16'h47FF, "R5");
    dp(1'b1, 16'h0022, 16'h0, 1'b0, 2, "R5");
    chk_addr(16'h4000, "R5");
    wr_reg(4'd7, 8'h01);
    set_addr(16'h47FE);
    dp(1'b1, 16'h3344, 16'h0, 1'b0, 3, "R5");
    chk_addr(16'h4000, "R5");
    wr_reg(4'd7, 8'h00);
    set_addr(16'h47FE);
    dp(1'b0, 16'h0, 16'h0044, 1'b1, 2, "R5");
    dp(1'b0, 16'h0, 16'h0033, 1'b1, 2, "R5");
    chk_addr(16'h4000, "R5");

    // R8 read at zero count
    set_cnt(16'd0);
    wr_reg(4'd8, 8'h40);
    dp(1'b0, 16'h0, 16'h00A1, 1'b1, 2, "R8");
    chk_addr(16'h4001, "R8"); chk_cnt(16'd0, "R8"); chk_reg(4'd8, 8'h40, "R8");

    // R12 request while busy ignored
    begin
      int a0;
      item_t it;
      set_addr(16'h4000); set_cnt(16'd5);
      @(negedge clk_i); #1;
      it.d = 16'h00A1; it.t = cyc; it.lat = 2; it.chk = 1'b1; it.tag = "R12";
      exp_q.push_back(it);
      a0 = acks;
      dp_req_i = 1'b1; dp_we_i = 1'b0;
      @(negedge clk_i); #1;
      @(negedge clk_i); #1;
      dp_req_i = 1'b0;
      repeat (6) @(negedge clk_i);
      #1;
      n_chk++;
      if (acks - a0 != 1) begin
        n_bad++;
        $display("FAIL R12 ack count: actual=%0d expected=1", acks - a0);
      end
      chk_addr(16'h4001, "R12");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule